// File: doc/BRIEF.md
# Accumulating-Hash Final Padding Detector

This block sits beside a multi-request accumulating hash. Software splits one message into several requests and appends its own padding to the last one. The block keeps a running count of the request bytes it has seen. For each request it decides, from the data alone, whether that request carries the final padding. A flag on a descriptor cannot mark a request as final. Only the data content can.

A request starts with a one-cycle `req_start` pulse carrying the request length in bytes. The block then reads the request through a byte-wide memory port with one cycle of read latency. It reads the eight trailing bytes first and takes them as a big-endian bit count. If the bit count makes sense, it reads one more byte: the byte where the padding would begin. The block ends the request with a one-cycle `done` pulse. At that point `is_final` tells whether the request is final, and `payload_len` gives the number of leading bytes to hash. The hash computation itself is done elsewhere.

Top module: `acc_pad_detect`

## Requirements
- R1: After reset, `running_total` is 0 and `busy`, `done` and `rd_en` are low. A reset in the middle of a sequence also returns `running_total` to 0.
- R2: A request that is found not to be final adds its length to `running_total`. The new value is visible in the cycle after `done`.
- R3: The eight bytes at request offsets len-8 to len-1 form a 64-bit value. The byte at len-8 is the most significant. This value divided by 8 (the low three bits are dropped) is the candidate message length in bytes.
- R4: If the candidate is greater than `running_total` plus the current length, the request is not final and `payload_len` equals the request length.
- R5: The padding size is (`running_total` + len − candidate), and the pad offset is len minus the padding size. If the padding size is 0 or greater than len, the offset lies outside the request. The request is then not final, `payload_len` equals len, and the marker byte is not read.
- R6: When the pad offset lies inside the request, the byte at that offset is read. If it equals 0x80, `is_final` is 1 and `payload_len` equals the offset. Otherwise `is_final` is 0 and `payload_len` equals len.
- R7: After a final request, `running_total` is 0 in the cycle after `done`.
- R8: A request shorter than 8 bytes is never final. It issues no memory reads, and its length is still added to the total.
- R9: `done` lasts exactly one cycle. `rd_en` is high only while `busy`, and every `rd_addr` is below the request length. A `req_start` that arrives while `busy` is ignored.
- R10: A request of 8 or more bytes makes exactly 8 reads when the marker is not checked, and 9 reads when it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle pulse that begins a request; accepted only when idle |
| req_len | input | LEN_W | Request length in bytes, sampled with `req_start` |
| busy | output | 1 | A request is in progress |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | LEN_W | Byte offset inside the current request |
| rd_data | input | 8 | Read byte, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle pulse at the end of the request |
| is_final | output | 1 | The request carries the final padding (valid with `done`) |
| payload_len | output | LEN_W | Bytes to hash from this request (valid with `done`) |
| running_total | output | ACC_W | Accumulated byte count of the current message |

## Verification
The hardest case to reach is a genuinely final request. Random bytes almost never form a bit count that is at most the running total, points inside the request and lands on a 0x80 byte. The bench therefore plants the padding on purpose. It chooses a padding size, writes the matching bit count big-endian into the tail and puts the marker at the resulting offset. Other requests plant a wrong marker, or a padding size one past the request length. Separate directed cases cover a padding size exactly equal to the length (offset 0), a padding size of 1 (the marker lands inside the tail bytes), and requests shorter than eight bytes.

// File: rtl/acc_pad_pkg.sv
// Package: shared state type for the padding detector.
package acc_pad_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAIL,
        ST_TWAIT,
        ST_EVAL,
        ST_MARK,
        ST_MWAIT,
        ST_DONE
    } pad_state_e;
endpackage

// File: rtl/acc_pad_accum.sv
// acc_pad_accum: holds the byte total of the message being accumulated.
// Assumes add_en and clr_en are never high together. sum_o is the total
// including the length on add_len.
module acc_pad_accum #(
    parameter int LEN_W = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             clr_en,
    input  logic [LEN_W-1:0] add_len,
    output logic [ACC_W-1:0] total_o,
    output logic [ACC_W-1:0] sum_o
);
    logic [ACC_W-1:0] total_q;

    // Combinational: total including the current request.
    assign sum_o   = total_q + ACC_W'(add_len);
    assign total_o = total_q;

    // Update the running total: clear after a final request, add otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      total_q <= '0;
        else if (clr_en) total_q <= '0;
        else if (add_en) total_q <= sum_o;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> total_q == '0); // R7
endmodule

// File: rtl/acc_pad_tailcap.sv
// acc_pad_tailcap: collects the trailing bytes into a big-endian 64-bit word.
// Assumes the bytes arrive in ascending address order, so that the first
// byte ends up most significant.
module acc_pad_tailcap (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        shift_en,
    input  logic [7:0]  byte_in,
    output logic [63:0] value_o
);
    logic [63:0] val_q;

    // Shift each new byte in at the low end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) val_q <= '0;
        else if (shift_en) val_q <= {val_q[55:0], byte_in};
    end

    assign value_o = val_q;
endmodule

// File: rtl/acc_pad_judge.sv
// acc_pad_judge: from the tail word, the total (including this request) and
// the request length, computes the pad offset and whether it is usable.
// Purely combinational. Assumes ACC_W >= LEN_W.
module acc_pad_judge #(
    parameter int LEN_W = 16,
    parameter int ACC_W = 32
) (
    input  logic [63:0]      tail_i,
    input  logic [ACC_W-1:0] sum_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             cand_ok_o,
    output logic             off_ok_o,
    output logic [LEN_W-1:0] offset_o
);
    logic [60:0]      cand;
    logic [ACC_W-1:0] pad;

    // Candidate check, padding size and offset range check.
    always_comb begin
        cand      = tail_i[63:3];
        cand_ok_o = cand <= 61'(sum_i);
        pad       = sum_i - ACC_W'(cand);
        off_ok_o  = cand_ok_o && (pad != '0) && (pad <= ACC_W'(len_i));
        offset_o  = len_i - LEN_W'(pad);
    end
endmodule

// File: rtl/acc_pad_detect.sv
// acc_pad_detect: decides per request whether it holds the final padding of
// an accumulated message. It reads the tail bytes, checks the bit count they
// hold, and reads the marker byte. The memory port has one cycle of read
// latency. req_start is ignored while busy.
module acc_pad_detect #(
    parameter int LEN_W = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             rd_en,
    output logic [LEN_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             done,
    output logic             is_final,
    output logic [LEN_W-1:0] payload_len,
    output logic [ACC_W-1:0] running_total
);
    import acc_pad_pkg::*;

    localparam int TAIL_BYTES = 8;
    localparam logic [7:0] MARKER = 8'h80;

    pad_state_e       state_q;
    logic [LEN_W-1:0] len_q, off_q, payload_q;
    logic [2:0]       cnt_q;
    logic             rvld_q, final_q;
    logic [63:0]      tail_w;
    logic [ACC_W-1:0] sum_w;
    logic             cand_ok_w, off_ok_w;
    logic [LEN_W-1:0] offset_w;
    logic             start_acc;

    assign start_acc = (state_q == ST_IDLE) && req_start;

    acc_pad_accum #(.LEN_W(LEN_W), .ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  ((state_q == ST_DONE) && !final_q),
        .clr_en  ((state_q == ST_DONE) && final_q),
        .add_len (len_q),
        .total_o (running_total),
        .sum_o   (sum_w)
    );

    acc_pad_tailcap u_tail (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_acc),
        .shift_en (rvld_q && (state_q == ST_TAIL || state_q == ST_TWAIT)),
        .byte_in  (rd_data),
        .value_o  (tail_w)
    );

    acc_pad_judge #(.LEN_W(LEN_W), .ACC_W(ACC_W)) u_judge (
        .tail_i    (tail_w),
        .sum_i     (sum_w),
        .len_i     (len_q),
        .cand_ok_o (cand_ok_w),
        .off_ok_o  (off_ok_w),
        .offset_o  (offset_w)
    );

    // Read strobe and address decode for the tail and marker phases.
    always_comb begin
        rd_en   = (state_q == ST_TAIL) || (state_q == ST_MARK);
        rd_addr = (state_q == ST_MARK) ? off_q
                                       : len_q - LEN_W'(TAIL_BYTES) + LEN_W'(cnt_q);
    end

    // Track which cycles carry read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rvld_q <= 1'b0;
        else        rvld_q <= rd_en;
    end

    // Request sequencer: tail reads, evaluation, marker read, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            len_q     <= '0;
            off_q     <= '0;
            payload_q <= '0;
            cnt_q     <= '0;
            final_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_start) begin
                    len_q     <= req_len;
                    payload_q <= req_len;
                    final_q   <= 1'b0;
                    cnt_q     <= '0;
                    state_q   <= (req_len < LEN_W'(TAIL_BYTES)) ? ST_DONE : ST_TAIL;
                end
                ST_TAIL: begin
                    cnt_q <= cnt_q + 3'd1;
                    if (cnt_q == 3'(TAIL_BYTES - 1)) state_q <= ST_TWAIT;
                end
                ST_TWAIT: state_q <= ST_EVAL;
                ST_EVAL: begin
                    off_q   <= offset_w;
                    state_q <= off_ok_w ? ST_MARK : ST_DONE;
                end
                ST_MARK: state_q <= ST_MWAIT;
                ST_MWAIT: begin
                    final_q   <= (rd_data == MARKER);
                    payload_q <= (rd_data == MARKER) ? off_q : len_q;
                    state_q   <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);
    assign is_final    = done && final_q;
    assign payload_len = payload_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy && (rd_addr < len_q)); // R9
    AST_SHORT_NOT_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        done && (len_q < LEN_W'(TAIL_BYTES)) |-> !is_final); // R8
    AST_NOTFINAL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done && !is_final |-> payload_len == len_q); // R4
    AST_FINAL_SHORTER: assert property (@(posedge clk) disable iff (!rst_n)
        is_final |-> payload_len < len_q); // R6
    AST_MARK_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) && !cand_ok_w |=> state_q == ST_DONE); // R5
    AST_ADD_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        done && !is_final |=> running_total == $past(running_total) + ACC_W'($past(len_q))); // R2
endmodule

// File: tb/acc_pad_detect_tb.sv
module acc_pad_detect_tb;
    localparam int LEN_W = 16;
    localparam int ACC_W = 32;
    localparam int MEMD  = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_start = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             busy, rd_en, done, is_final;
    logic [LEN_W-1:0] rd_addr, payload_len;
    logic [7:0]       rd_data = '0;
    logic [ACC_W-1:0] running_total;

    logic [7:0] mem [MEMD];
    int         n_chk = 0, n_bad = 0, n_rd = 0;
    longint     m_acc = 0;

    always #5 clk = ~clk;

    acc_pad_detect #(.LEN_W(LEN_W), .ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_len(req_len),
        .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .is_final(is_final), .payload_len(payload_len),
        .running_total(running_total)
    );

    // Memory model with one cycle of read latency, plus a read counter.
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr[7:0]];
            n_rd    <= n_rd + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Reference decision, computed from the requirements.
    task automatic model(input int len, output bit fin, output int pay, output int reads);
        longint unsigned tail, cand, sum, pad;
        fin = 0; pay = len; reads = 0;
        if (len < 8) return;
        reads = 8;
        tail = 0;
        for (int i = 0; i < 8; i++) tail = (tail << 8) | longint'(mem[len-8+i]);
        cand = tail >> 3;
        sum  = longint'(m_acc) + longint'(len);
        if (cand > sum) return;
        pad = sum - cand;
        if (pad == 0 || pad > longint'(len)) return;
        reads = 9;
        if (mem[len - int'(pad)] == 8'h80) begin
            fin = 1; pay = len - int'(pad);
        end
    endtask

    task automatic run_req(input int len);
        bit fin; int pay, reads, wd;
        model(len, fin, pay, reads);
        @(negedge clk);
        n_rd = 0;
        req_start = 1'b1; req_len = LEN_W'(len);
        @(negedge clk);
        req_start = 1'b0;
        wd = 0;
        while (!done) begin
            @(negedge clk);
            wd++;
            if (wd > 1000) begin
                n_chk++; n_bad++;
                $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
                finish_run();
            end
        end
        check("R6 is_final", longint'(is_final), longint'(fin));
        check("R6 R4 R5 payload_len", longint'(payload_len), longint'(pay));
        check("R10 R8 read count", longint'(n_rd), longint'(reads));
        @(negedge clk);
        check("R9 done pulse", longint'(done), 0);
        m_acc = fin ? 0 : m_acc + len;
        check("R2 R7 running_total", longint'(running_total), m_acc);
    endtask

    task automatic fill(input int len);
        for (int i = 0; i < len; i++) mem[i] = 8'($urandom);
    endtask

    // Write a bit count for the candidate len+acc-pad into the tail, big-endian.
    task automatic plant(input int len, input int pad, input logic [7:0] mk);
        longint unsigned bits;
        bits = longint'(m_acc + len - pad) * 8;
        for (int i = 0; i < 8; i++) mem[len-1-i] = 8'(bits >> (8*i));
        if (pad >= 1 && pad <= len) mem[len-pad] = mk;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < MEMD; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 running_total", longint'(running_total), 0);
        check("R1 busy", longint'(busy), 0);
        check("R1 done", longint'(done), 0);
        check("R1 rd_en", longint'(rd_en), 0);
        rst_n = 1'b1;

        // R8: short request with a marker present, never final.
        for (int i = 0; i < 7; i++) mem[i] = 8'h80;
        run_req(7);
        run_req(0);
        // R4: candidate too large.
        fill(40); for (int i = 32; i < 40; i++) mem[i] = 8'hff;
        run_req(40);
        // R5: padding one beyond the length.
        fill(30); plant(30, 31, 8'h80);
        run_req(30);
        // R6: wrong marker.
        fill(50); plant(50, 20, 8'h81);
        run_req(50);
        // R6 R7: real final, marker in the payload area.
        fill(64); plant(64, 17, 8'h80);
        run_req(64);
        // R6: padding equal to the whole request (offset 0), after a prior request.
        fill(20); run_req(20);
        fill(24); plant(24, 24, 8'h80);
        run_req(24);
        // R3: padding of one byte, the marker inside the tail region.
        fill(16); plant(16, 1, 8'h80);
        run_req(16);
        // R9: a start while busy is ignored.
        fill(12);
        @(negedge clk);
        req_start = 1'b1; req_len = 16'd12;
        @(negedge clk);
        req_len = 16'd99;
        @(negedge clk);
        req_start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R9 ignored start", longint'(running_total), m_acc + 12);
        m_acc += 12;
        repeat (2) @(negedge clk);
        check("R9 no second request", longint'(busy), 0);

        // Random mix.
        for (int k = 0; k < 120; k++) begin
            int len, kind, pad;
            len  = $urandom_range(200, 0);
            kind = $urandom_range(3, 0);
            fill(len);
            if (len >= 8) begin
                case (kind)
                    1: begin pad = $urandom_range(len, 1); plant(len, pad, 8'h80); end
                    2: begin pad = $urandom_range(len, 1); plant(len, pad, 8'h00); end
                    3: begin
                        pad = len + $urandom_range(8, 1);
                        if (m_acc + len >= pad) plant(len, pad, 8'h80);
                    end
                    default: ;
                endcase
            end
            run_req(len);
        end

        // R1: reset in the middle of an accumulation.
        fill(33); run_req(33);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_acc = 0;
        check("R1 total after reset", longint'(running_total), 0);
        finish_run();
    end
endmodule